// File: doc/BRIEF.md
# SPI Flash User-Command Transfer Engine

This block is the user-mode data path of a SPI flash controller. Software fills a 64-byte shared buffer through a small register window, programs a bit count and a few mode bits, and sets a start bit. The engine then clocks that many bits out on MOSI, most significant bit of each byte first. While the data-out phase runs it can also sample MISO. Each received bit overwrites the transmitted bit at the same buffer position, so the same buffer holds the reply when the burst ends.

SCK timing is not generated here. An external clock generator supplies a strobe that pulses once per SCK half-period, and every SCK edge happens on a strobe. Chip select can be kept asserted after a burst, so a flash command longer than the buffer can be sent as several chained bursts. Completion is reported through a sticky done flag that software clears before each start. A self-clearing soft reset aborts a burst at any time.

Top module: `spi_user_xfer`

## Requirements
- R1: After reset, the outputs are `spi_cs_n`=1 and `spi_sck`=0. The register readbacks are: control 0x08 bit 17 (memory-map enable) = 1, user 0x1C bit 2 (compatible mode) = 1, slave 0x30 bit 30 (slave role) = 1, slave bit 4 (done) = 0, and command 0x00 = 0.
- R2: Writing 1 to command bit 18 starts a burst only if four conditions all hold: control bit 17 = 0, user bit 27 (data-out enable) = 1, user bit 2 = 0 and slave bit 30 = 0. Otherwise the write has no effect: chip select stays high, no SCK edge occurs and done stays 0.
- R3: A burst produces exactly N+1 SCK rising edges, where N is the 9-bit field at user1 0x20 bits 25..17.
- R4: Burst bit n is bit 7-(n mod 8) of buffer byte n/8. Buffer byte k is lane k mod 4 (bits 8·(k mod 4)+7..8·(k mod 4)) of the word at 0x40+4·(k/4). MOSI carries bit n while SCK is low before rising edge n and while SCK stays high.
- R5: When user bit 0 (capture enable) = 1, the MISO value sampled at rising edge n replaces buffer bit n as placed by R4. When user bit 0 = 0, the buffer is left unchanged.
- R6: SCK changes only on a strobe. Chip select goes low when the burst starts, and the first rising edge comes exactly one strobe later. SCK is 0 whenever no burst is running.
- R7: Slave bit 4 becomes 1 when the last bit completes. Writing the slave register with bit 4 = 0 while idle clears it.
- R8: At the end of a burst, chip select stays low if user4 0x2C bit 30 (hold) = 1, and returns high if it is 0.
- R9: Command bit 18 reads back as 1 while a burst is running and 0 when the engine is idle.
- R10: While a burst runs, writes to the buffer and to the configuration registers are ignored.
- R11: Writing slave bit 31 = 1 aborts any burst. SCK returns to 0, chip select and the done flag are released, and bit 31 reads back as 0.
- R12: A burst started while chip select is held keeps chip select low throughout. Chip select rises only once, at the end of the final unheld burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Byte address of the 32-bit register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| half_stb | input | 1 | One pulse per SCK half-period from the clock generator |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions assume that a burst ends in only two ways, completion or soft reset. They also assume `half_stb` is a plain pulse train with no link to register traffic, so SCK motion is always traced to one strobe a cycle earlier. The stimulus pulses the strobe every second clock. It changes MISO only on falling clock edges, from a pattern indexed by the number of SCK rises seen. All writes are issued while idle, except the two cases that deliberately hit a running burst: the ignored writes and the abort. The sweep covers every bit count from 1 to 16 and the byte and word boundaries up to the full 512 bits.

// File: rtl/spi_user_xfer_pkg.sv
package spi_user_xfer_pkg;
  localparam int REG_ADDR_W = 7;

  localparam logic [REG_ADDR_W-1:0] OFF_CMD   = 7'h00;
  localparam logic [REG_ADDR_W-1:0] OFF_CTRL  = 7'h08;
  localparam logic [REG_ADDR_W-1:0] OFF_USER  = 7'h1C;
  localparam logic [REG_ADDR_W-1:0] OFF_USER1 = 7'h20;
  localparam logic [REG_ADDR_W-1:0] OFF_USER4 = 7'h2C;
  localparam logic [REG_ADDR_W-1:0] OFF_SLAVE = 7'h30;
  localparam int BUF_BASE = 'h40;

  localparam int GO_BIT       = 18;
  localparam int MMAP_BIT     = 17;
  localparam int DOUT_EN_BIT  = 27;
  localparam int CAP_EN_BIT   = 0;
  localparam int COMPAT_BIT   = 2;
  localparam int CNT_LSB      = 17;
  localparam int HOLD_BIT     = 30;
  localparam int DONE_BIT     = 4;
  localparam int ROLE_BIT     = 30;
  localparam int SWRST_BIT    = 31;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

  // burst bit index -> flat buffer bit: byte stays, bit order flips (MSB first)
  function automatic logic [15:0] burst_bit_pos(input logic [15:0] idx);
    return {idx[15:3], ~idx[2:0]};
  endfunction
endpackage

// File: rtl/spi_user_xfer_buf.sv
module spi_user_xfer_buf #(
  parameter int BUF_BYTES = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [$clog2(BUF_BYTES/4)-1:0]    wr_idx,
  input  logic [31:0]                       wr_data,
  input  logic [$clog2(BUF_BYTES/4)-1:0]    rd_idx,
  output logic [31:0]                       rd_data,
  input  logic [$clog2(BUF_BYTES*8)-1:0]    bit_pos,
  output logic                              bit_out,
  input  logic                              bit_we,
  input  logic                              bit_in
);
  localparam int WORDS  = BUF_BYTES / 4;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int POS_W  = $clog2(BUF_BYTES * 8);

  logic [31:0] words [WORDS];
  logic [WIDX_W-1:0] bit_word;
  assign bit_word = bit_pos[POS_W-1:5];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[w] <= '0;
      end else if (wr_en && wr_idx == WIDX_W'(w)) begin
        words[w] <= wr_data;
      end else if (bit_we && bit_word == WIDX_W'(w)) begin
        words[w][bit_pos[4:0]] <= bit_in;
      end
    end
  end

  assign rd_data = words[rd_idx];
  assign bit_out = words[bit_word][bit_pos[4:0]];
endmodule

// File: rtl/spi_user_xfer_shift.sv
module spi_user_xfer_shift
  import spi_user_xfer_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             half_stb,
  input  logic [CNT_W-1:0] last_idx,
  input  logic             cap_en,
  input  logic             hold_req,
  input  logic             miso,
  output logic             sck,
  output logic             busy,
  output logic             cs_held,
  output logic             cap_we,
  output logic             cap_bit,
  output logic             done_pulse,
  output logic [CNT_W-1:0] idx
);
  phase_e ph;
  logic   miso_q;
  logic   fall_stb;
  logic   at_last;

  assign fall_stb = (ph == PH_HIGH) && half_stb;
  assign at_last  = (idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      idx     <= '0;
      cs_held <= 1'b0;
      miso_q  <= 1'b0;
    end else if (abort) begin
      ph      <= PH_IDLE;
      idx     <= '0;
      cs_held <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph  <= PH_LOW;
          idx <= '0;
        end
        PH_LOW: if (half_stb) begin
          ph     <= PH_HIGH;
          miso_q <= miso;
        end
        PH_HIGH: if (half_stb) begin
          if (at_last) begin
            ph      <= PH_IDLE;
            cs_held <= hold_req;
          end else begin
            idx <= idx + 1'b1;
            ph  <= PH_LOW;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign sck        = (ph == PH_HIGH);
  assign busy       = (ph != PH_IDLE);
  assign cap_we     = fall_stb && cap_en;
  assign cap_bit    = miso_q;
  assign done_pulse = fall_stb && at_last;
endmodule

// File: rtl/spi_user_xfer.sv
module spi_user_xfer
  import spi_user_xfer_pkg::*;
#(
  parameter int BUF_BYTES = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  half_stb,
  output logic                  spi_sck,
  output logic                  spi_cs_n,
  output logic                  spi_mosi,
  input  logic                  spi_miso
);
  localparam int BITS   = BUF_BYTES * 8;
  localparam int CNT_W  = $clog2(BITS);
  localparam int WIDX_W = $clog2(BUF_BYTES / 4);

  logic             mmap_en, dout_en, cap_en, compat, role_slave, hold_cfg, done_flag;
  logic [CNT_W-1:0] cnt_m1;
  logic             busy, cs_held, cap_we, cap_bit, done_pulse, tx_bit, sck;
  logic [CNT_W-1:0] idx, pos;
  logic [31:0]      buf_rd;
  logic             is_buf, cfg_wr, go_req, go_pulse, abort_req;
  logic [WIDX_W-1:0] widx;

  assign is_buf    = (int'(reg_addr) >= BUF_BASE) && (int'(reg_addr) < BUF_BASE + BUF_BYTES);
  assign widx      = reg_addr[WIDX_W+1:2];
  assign cfg_wr    = reg_we && !busy;
  assign go_req    = cfg_wr && (reg_addr == OFF_CMD) && reg_wdata[GO_BIT];
  assign go_pulse  = go_req && !mmap_en && dout_en && !compat && !role_slave;
  assign abort_req = reg_we && (reg_addr == OFF_SLAVE) && reg_wdata[SWRST_BIT];
  assign pos       = CNT_W'(burst_bit_pos(16'(idx)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mmap_en    <= 1'b1;
      dout_en    <= 1'b0;
      cap_en     <= 1'b0;
      compat     <= 1'b1;
      role_slave <= 1'b1;
      hold_cfg   <= 1'b0;
      cnt_m1     <= '0;
    end else if (cfg_wr && !abort_req) begin
      case (reg_addr)
        OFF_CTRL:  mmap_en <= reg_wdata[MMAP_BIT];
        OFF_USER: begin
          dout_en <= reg_wdata[DOUT_EN_BIT];
          cap_en  <= reg_wdata[CAP_EN_BIT];
          compat  <= reg_wdata[COMPAT_BIT];
        end
        OFF_USER1: cnt_m1     <= reg_wdata[CNT_LSB +: CNT_W];
        OFF_USER4: hold_cfg   <= reg_wdata[HOLD_BIT];
        OFF_SLAVE: role_slave <= reg_wdata[ROLE_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                done_flag <= 1'b0;
    else if (abort_req)        done_flag <= 1'b0;
    else if (done_pulse)       done_flag <= 1'b1;
    else if (cfg_wr && reg_addr == OFF_SLAVE && !reg_wdata[DONE_BIT])
                               done_flag <= 1'b0;
  end

  spi_user_xfer_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr && is_buf),
    .wr_idx  (widx),
    .wr_data (reg_wdata),
    .rd_idx  (widx),
    .rd_data (buf_rd),
    .bit_pos (pos),
    .bit_out (tx_bit),
    .bit_we  (cap_we),
    .bit_in  (cap_bit)
  );

  spi_user_xfer_shift #(.CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (go_pulse),
    .abort      (abort_req),
    .half_stb   (half_stb),
    .last_idx   (cnt_m1),
    .cap_en     (cap_en),
    .hold_req   (hold_cfg),
    .miso       (spi_miso),
    .sck        (sck),
    .busy       (busy),
    .cs_held    (cs_held),
    .cap_we     (cap_we),
    .cap_bit    (cap_bit),
    .done_pulse (done_pulse),
    .idx        (idx)
  );

  assign spi_sck  = sck;
  assign spi_cs_n = ~(busy | cs_held);
  assign spi_mosi = busy & tx_bit;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_CMD:   reg_rdata[GO_BIT] = busy;
      OFF_CTRL:  reg_rdata[MMAP_BIT] = mmap_en;
      OFF_USER: begin
        reg_rdata[DOUT_EN_BIT] = dout_en;
        reg_rdata[CAP_EN_BIT]  = cap_en;
        reg_rdata[COMPAT_BIT]  = compat;
      end
      OFF_USER1: reg_rdata[CNT_LSB +: CNT_W] = cnt_m1;
      OFF_USER4: reg_rdata[HOLD_BIT] = hold_cfg;
      OFF_SLAVE: begin
        reg_rdata[ROLE_BIT] = role_slave;
        reg_rdata[DONE_BIT] = done_flag;
      end
      default:   if (is_buf) reg_rdata = buf_rd;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/spi_user_xfer_chk.sv
module spi_user_xfer_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             half_stb,
  input logic             sck,
  input logic             cs_n,
  input logic             mosi,
  input logic             busy,
  input logic             abort,
  input logic             done_flag,
  input logic             hold_cfg,
  input logic             mmap_en,
  input logic             dout_en,
  input logic             compat,
  input logic             role_slave,
  input logic [CNT_W-1:0] cnt_m1
);
  // R6
  sck_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != $past(sck)) && !$past(abort) |-> $past(half_stb));
  // R6
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R6
  sck_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);
  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck && $past(sck) |-> $stable(mosi));
  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!mmap_en && dout_en && !compat && !role_slave));
  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(abort) |-> done_flag);
  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(abort) && !hold_cfg |-> cs_n);
  // R8
  cs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(abort) && hold_cfg |-> !cs_n);
  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cnt_m1) && $stable(hold_cfg));
  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort) |-> !busy && cs_n && !done_flag);
endmodule

bind spi_user_xfer spi_user_xfer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .half_stb   (half_stb),
  .sck        (spi_sck),
  .cs_n       (spi_cs_n),
  .mosi       (spi_mosi),
  .busy       (busy),
  .abort      (abort_req),
  .done_flag  (done_flag),
  .hold_cfg   (hold_cfg),
  .mmap_en    (mmap_en),
  .dout_en    (dout_en),
  .compat     (compat),
  .role_slave (role_slave),
  .cnt_m1     (cnt_m1)
);

// File: tb/spi_user_xfer_bench.sv
module spi_user_xfer_bench;
  import spi_user_xfer_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int STB_DIV    = 2;
  localparam int NBYTES     = 64;
  localparam int MAX_BITS   = NBYTES * 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        half_stb = 1'b0;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_user_xfer u_spi_user_xfer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .half_stb(half_stb),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      half_stb <= (div == STB_DIV - 1);
      div = (div == STB_DIV - 1) ? 0 : div + 1;
    end
  end

  // serial slave model
  int edge_cnt = 0;
  int base = 0;
  int seed_rx = 0;
  bit mosi_log [MAX_BITS];
  int cs_rises = 0;

  function automatic bit rx_pat(input int n, input int s);
    return bit'(((n * 13 + s * 5 + (n >> 4)) >> 2) & 1);
  endfunction

  function automatic logic [7:0] tx_byte(input int k, input int s);
    return 8'((k * 29 + s * 11 + 5) & 255);
  endfunction

  always @(posedge spi_sck) begin
    if (edge_cnt >= base && edge_cnt - base < MAX_BITS) mosi_log[edge_cnt - base] = spi_mosi;
    edge_cnt = edge_cnt + 1;
  end

  always @(posedge spi_cs_n) cs_rises = cs_rises + 1;

  initial forever begin
    @(negedge clk);
    spi_miso <= rx_pat(edge_cnt - base, seed_rx);
  end

  // strobes counted from chip-select fall to first SCK rise
  bit prev_cs = 1'b1;
  bit seen_rise = 1'b0;
  int lead = 0;
  int lead_at_rise = -1;
  initial forever begin
    @(negedge clk);
    if (spi_cs_n) begin
      lead = 0;
      seen_rise = 1'b0;
    end else if (!seen_rise) begin
      if (!prev_cs) lead = lead + int'(half_stb);
      if (spi_sck) begin
        seen_rise = 1'b1;
        lead_at_rise = lead;
      end
    end
    prev_cs = spi_cs_n;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  logic [7:0] tx_bytes [NBYTES];
  logic [7:0] exp_buf  [NBYTES];

  task automatic load_buf(input int s);
    for (int w = 0; w < NBYTES / 4; w++) begin
      logic [31:0] word;
      for (int l = 0; l < 4; l++) begin
        tx_bytes[4*w+l] = tx_byte(4*w+l, s);
        exp_buf[4*w+l]  = tx_bytes[4*w+l];
        word[8*l +: 8]  = tx_bytes[4*w+l];
      end
      reg_write(7'(BUF_BASE + 4*w), word);
    end
  endtask

  task automatic configure(input int nbits, input bit cap, input bit hold);
    reg_write(OFF_USER1, 32'(nbits - 1) << CNT_LSB);
    reg_write(OFF_USER, (32'd1 << DOUT_EN_BIT) | 32'(cap));
    reg_write(OFF_USER4, 32'(hold) << HOLD_BIT);
    reg_write(OFF_SLAVE, 32'd0);
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] d;
    ok = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      reg_read(OFF_SLAVE, d);
      if (d[DONE_BIT]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic check_results(input int nbits, input bit cap, input int s);
    int mism;
    logic [31:0] d;
    chk(edge_cnt - base == nbits, "R3", "sck rising edges", edge_cnt - base, nbits);
    mism = 0;
    for (int n = 0; n < nbits; n++)
      if (mosi_log[n] != tx_bytes[n/8][7 - n%8]) mism++;
    chk(mism == 0, "R4", "mosi bit mismatches", mism, 0);
    if (cap)
      for (int n = 0; n < nbits; n++) exp_buf[n/8][7 - n%8] = rx_pat(n, s);
    mism = 0;
    for (int w = 0; w < NBYTES / 4; w++) begin
      reg_read(7'(BUF_BASE + 4*w), d);
      for (int l = 0; l < 4; l++) if (d[8*l +: 8] != exp_buf[4*w+l]) mism++;
    end
    chk(mism == 0, "R5", "buffer byte mismatches", mism, 0);
  endtask

  task automatic run_burst(input int nbits, input bit cap, input bit hold,
                           input int s, input bit fresh);
    logic [31:0] d;
    bit ok;
    load_buf(s);
    configure(nbits, cap, hold);
    base = edge_cnt;
    seed_rx = s;
    reg_write(OFF_CMD, 32'd1 << GO_BIT);
    if (nbits >= 4) begin
      reg_read(OFF_CMD, d);
      chk(d[GO_BIT] == 1'b1, "R9", "start bit while busy", d[GO_BIT], 1);
    end
    wait_done(ok);
    chk(ok, "R7", "done flag", ok, 1);
    reg_read(OFF_CMD, d);
    chk(d[GO_BIT] == 1'b0, "R9", "start bit when idle", d[GO_BIT], 0);
    check_results(nbits, cap, s);
    chk(spi_sck == 1'b0, "R6", "sck idle low", spi_sck, 0);
    chk(spi_cs_n == !hold, "R8", "cs after burst", spi_cs_n, !hold);
    if (fresh) chk(lead_at_rise == 1, "R6", "strobes cs-to-first-rise", lead_at_rise, 1);
  endtask

  task automatic blocked_start(input string what);
    logic [31:0] d;
    int e0;
    e0 = edge_cnt;
    reg_write(OFF_CMD, 32'd1 << GO_BIT);
    repeat (20) @(negedge clk);
    chk(spi_cs_n == 1'b1 && edge_cnt == e0, "R2", what, {spi_cs_n, 32'(edge_cnt - e0)}, 64'h1_0000_0000);
    reg_read(OFF_SLAVE, d);
    chk(d[DONE_BIT] == 1'b0, "R2", {what, " done"}, d[DONE_BIT], 0);
  endtask

  localparam int SWEEP_N = 13;
  localparam int SWEEP [SWEEP_N] = '{24, 31, 32, 33, 63, 64, 65, 100, 255, 256, 257, 511, 512};

  initial begin
    logic [31:0] d;
    bit ok;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1", "pins after reset", {spi_cs_n, spi_sck}, 2'b10);
    reg_read(OFF_CTRL, d);  chk(d == (32'd1 << MMAP_BIT), "R1", "control", d, 32'd1 << MMAP_BIT);
    reg_read(OFF_USER, d);  chk(d == (32'd1 << COMPAT_BIT), "R1", "user", d, 32'd1 << COMPAT_BIT);
    reg_read(OFF_SLAVE, d); chk(d == (32'd1 << ROLE_BIT), "R1", "slave", d, 32'd1 << ROLE_BIT);
    reg_read(OFF_CMD, d);   chk(d == 32'd0, "R1", "command", d, 0);

    // R2 each gating condition blocks the start
    configure(8, 1'b0, 1'b0);
    reg_write(OFF_SLAVE, 32'd1 << ROLE_BIT);
    blocked_start("memory-map enabled");
    reg_write(OFF_CTRL, 32'd0);
    blocked_start("slave role");
    reg_write(OFF_SLAVE, 32'd0);
    reg_write(OFF_USER, (32'd1 << DOUT_EN_BIT) | (32'd1 << COMPAT_BIT));
    blocked_start("compatible mode");
    reg_write(OFF_USER, 32'd1);
    blocked_start("data-out disabled");

    // R3 R4 R5 sweep over bit counts, capture on and off
    for (int nb = 1; nb <= 16; nb++) run_burst(nb, bit'(nb % 2), 1'b0, nb, 1'b1);
    for (int i = 0; i < SWEEP_N; i++) run_burst(SWEEP[i], bit'(i % 2 == 0), 1'b0, 40 + i, 1'b1);

    // R7 done clears on write of 0
    reg_write(OFF_SLAVE, 32'd0);
    reg_read(OFF_SLAVE, d);
    chk(d[DONE_BIT] == 1'b0, "R7", "done cleared", d[DONE_BIT], 0);

    // R8 R12 chained bursts under held chip select
    run_burst(16, 1'b1, 1'b1, 70, 1'b1);
    r0 = cs_rises;
    run_burst(24, 1'b1, 1'b0, 71, 1'b0);
    chk(cs_rises == r0 + 1, "R12", "cs rises over held chain", cs_rises - r0, 1);

    // R10 writes during a burst are ignored
    load_buf(80);
    configure(MAX_BITS, 1'b0, 1'b0);
    base = edge_cnt;
    seed_rx = 80;
    reg_write(OFF_CMD, 32'd1 << GO_BIT);
    reg_write(7'(BUF_BASE), 32'hDEADBEEF);
    reg_write(OFF_USER1, 32'd3 << CNT_LSB);
    reg_read(OFF_USER1, d);
    chk(d == (32'(MAX_BITS - 1) << CNT_LSB), "R10", "bit count while busy", d, 32'(MAX_BITS - 1) << CNT_LSB);
    wait_done(ok);
    chk(ok, "R10", "burst completes", ok, 1);
    check_results(MAX_BITS, 1'b0, 80);

    // R11 soft reset aborts
    load_buf(90);
    configure(MAX_BITS, 1'b1, 1'b1);
    base = edge_cnt;
    reg_write(OFF_CMD, 32'd1 << GO_BIT);
    repeat (40) @(negedge clk);
    reg_write(OFF_SLAVE, 32'd1 << SWRST_BIT);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R11", "pins after abort", {spi_cs_n, spi_sck}, 2'b10);
    chk(edge_cnt - base < MAX_BITS, "R11", "burst cut short", edge_cnt - base, MAX_BITS);
    reg_read(OFF_CMD, d);
    chk(d[GO_BIT] == 1'b0, "R11", "idle after abort", d[GO_BIT], 0);
    reg_read(OFF_SLAVE, d);
    chk(d[SWRST_BIT] == 1'b0 && d[DONE_BIT] == 1'b0, "R11", "slave readback", d, 0);
    run_burst(8, 1'b1, 1'b0, 91, 1'b1);

    summary();
    $finish;
  end
endmodule